// File: doc/BRIEF.md
# Status Word Restore and Move Unit

This combinational unit produces the next 64-bit machine status word for two operations: a return from an interrupt handler, and a move of a general register into the status word. It takes an operation select, the current status word, two save registers (the saved fetch address and the saved status) and the source register for the move. It gives back the new status word with a write-enable, and for a return also the address to fetch from next with a redirect flag.

All bit numbers below count from the most significant end: bit k sits at vector index 63-k, so bit 0 is the most significant bit. Most of the new word is copied from the source, which is save register 1 for a return and the move source for a move. A few bits are kept from the current status word instead. The hypervisor bit (bit 3) and the bit paired with it (bit 51) are only restored when the current hypervisor bit is set. The 3-bit transactional state field (bits 29 to 31) keeps its old value in one forbidden case: the old field is 0b010 and the source field is 0b000.

Operation encoding on `op_sel`: 2'b01 is return, 2'b10 is move, and 2'b00 and 2'b11 do nothing.

Top module: `status_restore_move`

## Requirements
- R1: When `op_sel` is 2'b00 or 2'b11, `new_status`, `fetch_pc`, `status_we` and `fetch_redirect` are all zero.
- R2: On return (`op_sel`=2'b01), new bit 3 (index 60) equals current bit 3 AND save-register-1 bit 3.
- R3: On return, new bit 51 (index 12) takes save-register-1 bit 51 when current bit 3 is 1, and keeps current bit 51 when current bit 3 is 0.
- R4: For both operations, bits 29..31 (indices 34..32, bit 29 the field's most significant bit) keep the current field when the current field is 0b010 and the source field is 0b000.
- R5: For both operations, bits 29..31 take the source field in every other combination of current and source field.
- R6: Every bit not named in R2 to R5 is copied from the source; on a move, bits 3 and 51 also come from the move source.
- R7: On return, `fetch_pc` equals save register 0 with indices 1 and 0 cleared and `fetch_redirect` is 1; on a move both are zero.
- R8: `status_we` is 1 for a return and for a move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 2 | Operation: 01 return, 10 move, 00/11 none |
| cur_status | input | 64 | Current status word |
| save0 | input | 64 | Saved fetch address |
| save1 | input | 64 | Saved status word |
| move_src | input | 64 | Source register for a move |
| new_status | output | 64 | Computed status word |
| status_we | output | 1 | Status word write-enable |
| fetch_pc | output | 64 | Next fetch address on return |
| fetch_redirect | output | 1 | Fetch redirect valid on return |

## Verification
The bench sweeps all 64 pairs of old and source transactional fields for both operations, since a design that drops the keep-old branch would let 0b000 overwrite 0b010 and one with a loose pattern match would keep the old field where the source should win. Return cases with bit 3 clear and bit 51 differing between old and saved words catch a design that copies both bits unconditionally, which would raise bit 3 or lose bit 51. Move cases with bits 3 and 51 set only in the old word catch a design that applies the return-only rules to a move. Saved addresses with low bits set catch a missing alignment mask, and the two idle encodings catch a design that leaks a result or a write-enable.

// File: rtl/status_pkg.sv
package status_pkg;

  typedef enum logic [1:0] {
    SR_OP_IDLE   = 2'b00,
    SR_OP_RETURN = 2'b01,
    SR_OP_MOVE   = 2'b10,
    SR_OP_RSVD   = 2'b11
  } sr_op_e;

  // Number of source paths: return (save register 1) and move (move source)
  localparam int unsigned SR_NPATH   = 2;
  localparam int unsigned SR_PATH_RET = 0;
  localparam int unsigned SR_PATH_MOV = 1;

  // Convert a most-significant-first bit number into a vector index
  function automatic int unsigned msb0_to_idx(input int unsigned width,
                                              input int unsigned pos);
    return width - 1 - pos;
  endfunction

endpackage

// File: rtl/status_ts_guard.sv
module status_ts_guard #(
  parameter int unsigned  FW      = 3,
  parameter logic [FW-1:0] OLD_PAT = 3'b010,
  parameter logic [FW-1:0] SRC_PAT = 3'b000
) (
  input  logic [FW-1:0] old_f,
  input  logic [FW-1:0] src_f,
  output logic          keep_old
);

  // The forbidden transition keeps the old field; every other pair takes
  // the source. Both arms are written out on purpose.
  always_comb begin
    if ((old_f == OLD_PAT) && (src_f == SRC_PAT)) begin
      keep_old = 1'b1;
    end else begin
      keep_old = 1'b0;
    end
  end

endmodule

// File: rtl/status_merge.sv
module status_merge #(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0] old_word,
  input  logic [XLEN-1:0] src_word,
  input  logic [XLEN-1:0] keep_mask,
  output logic [XLEN-1:0] merged
);

  // Range copy from the source, then restore the masked bits from old
  always_comb begin
    merged = src_word;
    merged = (merged & ~keep_mask) | (old_word & keep_mask);
  end

endmodule

// File: rtl/status_restore_move.sv
module status_restore_move
  import status_pkg::*;
#(
  parameter int unsigned XLEN     = 64,
  parameter int unsigned HV_POS   = 3,
  parameter int unsigned PAIR_POS = 51,
  parameter int unsigned TS_FIRST = 29,
  parameter int unsigned TS_LAST  = 31,
  parameter int unsigned PC_ALIGN = 2,
  parameter logic [2:0]  TS_OLD_PAT = 3'b010,
  parameter logic [2:0]  TS_SRC_PAT = 3'b000
) (
  input  logic [1:0]      op_sel,
  input  logic [XLEN-1:0] cur_status,
  input  logic [XLEN-1:0] save0,
  input  logic [XLEN-1:0] save1,
  input  logic [XLEN-1:0] move_src,
  output logic [XLEN-1:0] new_status,
  output logic            status_we,
  output logic [XLEN-1:0] fetch_pc,
  output logic            fetch_redirect
);

  localparam int unsigned HV_IDX   = msb0_to_idx(XLEN, HV_POS);
  localparam int unsigned PAIR_IDX = msb0_to_idx(XLEN, PAIR_POS);
  localparam int unsigned TS_W     = TS_LAST - TS_FIRST + 1;
  localparam int unsigned TS_LSB   = msb0_to_idx(XLEN, TS_LAST);
  localparam logic [XLEN-1:0] HV_MASK    = {{(XLEN-1){1'b0}}, 1'b1} << HV_IDX;
  localparam logic [XLEN-1:0] PAIR_MASK  = {{(XLEN-1){1'b0}}, 1'b1} << PAIR_IDX;
  localparam logic [XLEN-1:0] TS_MASK    = {{(XLEN-TS_W){1'b0}}, {TS_W{1'b1}}} << TS_LSB;
  localparam logic [XLEN-1:0] ALIGN_MASK = {{(XLEN-PC_ALIGN){1'b0}}, {PC_ALIGN{1'b1}}};

  sr_op_e          op;
  logic            is_ret;
  logic            is_mov;
  logic [XLEN-1:0] path_src   [SR_NPATH];
  logic [XLEN-1:0] path_keep  [SR_NPATH];
  logic [XLEN-1:0] path_out   [SR_NPATH];
  logic            ts_keep    [SR_NPATH];
  logic [XLEN-1:0] hv_keep;

  always_comb begin
    op     = sr_op_e'(op_sel);
    is_ret = (op == SR_OP_RETURN);
    is_mov = (op == SR_OP_MOVE);
  end

  assign path_src[SR_PATH_RET] = save1;
  assign path_src[SR_PATH_MOV] = move_src;

  // Return only: bits 3 and 51 stay when the current hypervisor bit is clear
  // (bit 3 then reads 0 either way, matching old AND saved).
  assign hv_keep = cur_status[HV_IDX] ? '0 : (HV_MASK | PAIR_MASK);

  for (genvar p = 0; p < SR_NPATH; p++) begin : g_path
    status_ts_guard #(
      .FW      (TS_W),
      .OLD_PAT (TS_OLD_PAT),
      .SRC_PAT (TS_SRC_PAT)
    ) u_guard (
      .old_f    (cur_status[TS_LSB +: TS_W]),
      .src_f    (path_src[p][TS_LSB +: TS_W]),
      .keep_old (ts_keep[p])
    );

    if (p == SR_PATH_RET) begin : g_ret
      assign path_keep[p] = hv_keep | (ts_keep[p] ? TS_MASK : '0);
    end else begin : g_mov
      assign path_keep[p] = ts_keep[p] ? TS_MASK : '0;
    end

    status_merge #(
      .XLEN (XLEN)
    ) u_merge (
      .old_word  (cur_status),
      .src_word  (path_src[p]),
      .keep_mask (path_keep[p]),
      .merged    (path_out[p])
    );
  end

  always_comb begin
    new_status     = '0;
    status_we      = 1'b0;
    fetch_pc       = '0;
    fetch_redirect = 1'b0;
    case (op)
      SR_OP_RETURN: begin
        new_status     = path_out[SR_PATH_RET];
        status_we      = 1'b1;
        fetch_pc       = save0 & ~ALIGN_MASK;
        fetch_redirect = 1'b1;
      end
      SR_OP_MOVE: begin
        new_status = path_out[SR_PATH_MOV];
        status_we  = 1'b1;
      end
      default: ;
    endcase
  end

  // Checks against the port-level rules
  always_comb begin
    if (!is_ret && !is_mov) begin
      assert_idle_quiet_R1: assert (new_status == '0 && !status_we && !fetch_redirect)
        else $error("idle op produced output");
    end
    if (is_ret) begin
      assert_hv_and_R2: assert (new_status[HV_IDX] == (cur_status[HV_IDX] & save1[HV_IDX]))
        else $error("return hv bit wrong");
    end
    if (is_ret && !cur_status[HV_IDX]) begin
      assert_pair_hold_R3: assert (new_status[PAIR_IDX] == cur_status[PAIR_IDX])
        else $error("return paired bit not held");
    end
    if (is_ret && cur_status[TS_LSB +: TS_W] == TS_OLD_PAT
        && save1[TS_LSB +: TS_W] == TS_SRC_PAT) begin
      assert_ts_keep_ret_R4: assert (new_status[TS_LSB +: TS_W] == TS_OLD_PAT)
        else $error("return ts field not kept");
    end
    if (is_mov && cur_status[TS_LSB +: TS_W] == TS_OLD_PAT
        && move_src[TS_LSB +: TS_W] == TS_SRC_PAT) begin
      assert_ts_keep_mov_R4: assert (new_status[TS_LSB +: TS_W] == TS_OLD_PAT)
        else $error("move ts field not kept");
    end
    if (fetch_redirect) begin
      assert_pc_align_R7: assert ((fetch_pc & ALIGN_MASK) == '0 && is_ret)
        else $error("redirect misaligned or on wrong op");
    end
    if (is_ret || is_mov) begin
      assert_we_set_R8: assert (status_we)
        else $error("write enable missing");
    end
  end

endmodule

// File: tb/test_status_restore_move.sv
module test_status_restore_move;

  typedef struct packed {
    logic [15:0] tag;
    logic [1:0]  op;
    logic [63:0] old_w;
    logic [63:0] s0;
    logic [63:0] s1;
    logic [63:0] src;
    logic [63:0] exp_st;
    logic        exp_we;
    logic [63:0] exp_pc;
    logic        exp_rd;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    // R6: plain return, everything from save register 1
    '{"R6", 2'b01, 64'h1000_0000_0000_0000, 64'h0000_0000_0000_7007,
      64'h1234_5678_9ABC_DEF0, 64'h0, 64'h1234_5678_9ABC_DEF0, 1'b1,
      64'h0000_0000_0000_7004, 1'b1},
    // R3: hv clear -> bit3 zero, bit51 held at 0, ts 010 kept vs 000 (R4)
    '{"R3", 2'b01, 64'h0000_0002_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF,
      64'h1234_5678_9ABC_DEF0, 64'h0, 64'h0234_567A_9ABC_CEF0, 1'b1,
      64'hFFFF_FFFF_FFFF_FFFC, 1'b1},
    // R2: hv set, saved bit3/bit51 clear -> both cleared
    '{"R2", 2'b01, 64'h1000_0000_0000_1000, 64'h0000_0000_0000_0002,
      64'h0EEE_0000_0000_0000, 64'h0, 64'h0EEE_0000_0000_0000, 1'b1,
      64'h0, 1'b1},
    // R4: move keeps ts 010 against 000; old bits 3 and 51 not kept (R6)
    '{"R4", 2'b10, 64'h1000_0002_0000_1000, 64'hDEAD, 64'hBEEF,
      64'h0, 64'h0000_0002_0000_0000, 1'b1, 64'h0, 1'b0},
    // R5: move, old 010 src 001 -> source wins
    '{"R5", 2'b10, 64'h0000_0002_0000_0000, 64'h0, 64'h0,
      64'hAAAA_AAA1_5555_5555, 64'hAAAA_AAA1_5555_5555, 1'b1, 64'h0, 1'b0},
    // R5: move, old 011 src 000 -> source wins
    '{"R5", 2'b10, 64'h0000_0003_0000_0000, 64'h0, 64'h0,
      64'hFFFF_FFF8_FFFF_FFFF, 64'hFFFF_FFF8_FFFF_FFFF, 1'b1, 64'h0, 1'b0},
    // R1: idle 00 with busy inputs
    '{"R1", 2'b00, 64'hFFFF_FFFF_FFFF_FFFF, 64'h7007, 64'hFFFF_FFFF_FFFF_FFFF,
      64'h1234, 64'h0, 1'b0, 64'h0, 1'b0},
    // R1: encoding 11 is also idle
    '{"R1", 2'b11, 64'h1000_0002_0000_1000, 64'h7007, 64'h1234_5678_9ABC_DEF0,
      64'h1234, 64'h0, 1'b0, 64'h0, 1'b0},
    // R2: return, ts 010 vs 111 -> source; bit3 = 1 & 0
    '{"R2", 2'b01, 64'h1000_0002_0000_1000, 64'h0000_0000_0000_0C01,
      64'h0000_0007_0000_0000, 64'h0, 64'h0000_0007_0000_0000, 1'b1,
      64'h0000_0000_0000_0C00, 1'b1}
  };

  logic        clk;
  logic        rst_n;
  logic [1:0]  op_sel;
  logic [63:0] cur_status, save0, save1, move_src;
  logic [63:0] new_status, fetch_pc;
  logic        status_we, fetch_redirect;

  int checks;
  int failures;
  int cyc;

  status_restore_move i_status_restore_move (
    .op_sel         (op_sel),
    .cur_status     (cur_status),
    .save0          (save0),
    .save1          (save1),
    .move_src       (move_src),
    .new_status     (new_status),
    .status_we      (status_we),
    .fetch_pc       (fetch_pc),
    .fetch_redirect (fetch_redirect)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s got=%h exp=%h", req, what, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic apply(input logic [1:0] o, input logic [63:0] ow,
                       input logic [63:0] a0, input logic [63:0] a1,
                       input logic [63:0] ms);
    @(negedge clk);
    op_sel = o; cur_status = ow; save0 = a0; save1 = a1; move_src = ms;
    #1;
  endtask

  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
      end
    end
  end

  initial begin
    checks = 0; failures = 0;
    op_sel = 2'b00; cur_status = '0; save0 = '0; save1 = '0; move_src = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // Reset state: idle select, all outputs quiet (R1)
    @(negedge clk); #1;
    check("R1", "reset status", new_status, 64'h0);
    check("R1", "reset we", {63'h0, status_we}, 64'h0);
    check("R1", "reset redirect", {63'h0, fetch_redirect}, 64'h0);

    // Vector table
    for (int i = 0; i < NVEC; i++) begin
      string t;
      t = string'(VECS[i].tag);
      apply(VECS[i].op, VECS[i].old_w, VECS[i].s0, VECS[i].s1, VECS[i].src);
      check(t, "status", new_status, VECS[i].exp_st);
      check("R8", "we", {63'h0, status_we}, {63'h0, VECS[i].exp_we});
      check("R7", "pc", fetch_pc, VECS[i].exp_pc);
      check("R7", "redirect", {63'h0, fetch_redirect}, {63'h0, VECS[i].exp_rd});
    end

    // Field sweep on bits 29..31 (indices 34..32) for both operations: R4 and R5
    for (int o = 0; o < 8; o++) begin
      for (int s = 0; s < 8; s++) begin
        logic [2:0]  of, sf, ef;
        logic [63:0] ow, sw, ew;
        of = 3'(o); sf = 3'(s);
        ef = (of == 3'b010 && sf == 3'b000) ? of : sf;
        ow = 64'h1000_0000_0000_1000 | ({61'h0, of} << 32);
        sw = 64'h1000_0000_0000_1000 | ({61'h0, sf} << 32) | 64'h55;
        ew = 64'h1000_0000_0000_1055 | ({61'h0, ef} << 32);
        apply(2'b10, ow, 64'h0, 64'h0, sw);
        check((of == 3'b010 && sf == 3'b000) ? "R4" : "R5", "move ts sweep",
              new_status, ew);
        apply(2'b01, ow, 64'h0, sw, 64'h0);
        check((of == 3'b010 && sf == 3'b000) ? "R4" : "R5", "return ts sweep",
              new_status, ew);
      end
    end

    // R3: hv set, paired bit differs -> saved value taken
    apply(2'b01, 64'h1000_0000_0000_0000, 64'h0, 64'h1000_0000_0000_1000, 64'h0);
    check("R3", "pair from saved", new_status, 64'h1000_0000_0000_1000);
    // R3: hv clear, old pair 1, saved pair 0 -> held at 1; R2 bit3 stays 0
    apply(2'b01, 64'h0000_0000_0000_1000, 64'h0, 64'h1000_0000_0000_0000, 64'h0);
    check("R3", "pair held", new_status, 64'h0000_0000_0000_1000);
    // R6: move with only old bits set gives the source unchanged
    apply(2'b10, 64'hFFFF_FFFD_FFFF_FFFF, 64'h0, 64'h0, 64'h0123_4567_89AB_CDEF);
    check("R6", "move copy", new_status, 64'h0123_4567_89AB_CDEF);

    finish_run();
  end

endmodule